// File: doc/BRIEF.md
# Two-Lane Shift-Mask Interpolator

This block computes addresses and table indices from a pair of running accumulators. Each of its two lanes holds an accumulator, a base and a control word. The lane rotates its accumulator right, keeps one contiguous run of bits, optionally sign-extends that run, and adds its base. A third base combines the two masked values into a full result. Software sets the block up once. It then reads results repeatedly. Each read is either side-effect-free (peek) or feeds every lane's result back into its own accumulator (pop), which advances the accumulators on every access.

The register port has independent read and write channels that can both act in the same cycle. Read data is combinational from the current state, so it is valid in the cycle of the request. Every state change made by a write or a pop becomes visible on the clock edge that ends that cycle.

Word addresses (4 bits):
- 0, 1: accumulators.
- 2, 3, 4: bases 0, 1 and 2.
- 5, 6: add ports.
- 7: packed base.
- 8, 9: lane controls.
- 10, 11, 12: peek of lane 0, lane 1 and full.
- 13, 14, 15: pop of lane 0, lane 1 and full.

Lane control layout: rotate amount in bits [4:0], low mask bit in [9:5], high mask bit in [14:10], signed flag in bit 15.

Top module: `shift_mask_interp`

## Requirements
- R1: After reset every accumulator, base and control register is zero, so every readable address returns 0.
- R2: Writes to accumulator, base and control addresses are read back from the same address on later cycles. Controls keep only bits [15:0]; the upper bits read back as 0.
- R3: A lane's raw value is its accumulator rotated right by control bits [4:0]. All bits outside the range from control bits [9:5] (low) to control bits [14:10] (high) are then cleared. An empty range (low above high) gives 0.
- R4: When control bit 15 is set, the bits above the high mask bit of the raw value are copies of the masked value's bit at the high mask bit.
- R5: A lane peek (address 10 or 11) returns that lane's base plus its raw value, modulo 2^32.
- R6: A full peek (address 12) returns base 2 plus the raw values of both lanes, modulo 2^32.
- R7: A write to add port 5 or 6 adds the written value to accumulator 0 or 1, modulo 2^32.
- R8: A read of add port 5 or 6 returns the raw value of lane 0 or 1, without its base added.
- R9: A write to address 7 loads base 0 from data bits [15:0] and base 1 from bits [31:16] in one cycle. Each half is sign-extended when its own lane's control bit 15 is set, and zero-extended otherwise.
- R10: Peek reads change no state.
- R11: A pop read (addresses 13, 14, 15) returns the same value as the matching peek. On that edge it loads each accumulator with its own lane result.
- R12: When a write to an accumulator or its add port coincides with a pop, the write decides that accumulator. The other accumulator still takes its pop value.
- R13: Read data is 0 when no read is requested, and also for the write-only packed base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read result, valid in the request cycle |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |

## Verification
Read results depend only on the state before the current edge. The bench therefore drives each request after a falling edge and compares rd_data one nanosecond later, in the same cycle. Writes and pops take effect on the next rising edge. The bench model commits its state update only after that edge, so the next cycle's reads reflect it with no offset. Directed sequences pin exact constants for rotation, masking, sign extension and packed bases. Seeded random traffic then compares every read against the model, including pops that collide with writes.

// File: rtl/interp_pkg.sv
package interp_pkg;

   typedef enum logic [3:0] {
      RA_ACC0  = 4'd0,
      RA_ACC1  = 4'd1,
      RA_BASE0 = 4'd2,
      RA_BASE1 = 4'd3,
      RA_BASE2 = 4'd4,
      RA_ADD0  = 4'd5,
      RA_ADD1  = 4'd6,
      RA_BPACK = 4'd7,
      RA_CTRL0 = 4'd8,
      RA_CTRL1 = 4'd9,
      RA_PEEK0 = 4'd10,
      RA_PEEK1 = 4'd11,
      RA_PEEKF = 4'd12,
      RA_POP0  = 4'd13,
      RA_POP1  = 4'd14,
      RA_POPF  = 4'd15
   } reg_addr_e;

   localparam int NUM_LANES = 2;
   localparam int NUM_BASES = 3;

   typedef struct packed {
      logic [NUM_LANES-1:0] acc_wr;
      logic [NUM_LANES-1:0] add_wr;
      logic [NUM_BASES-1:0] base_wr;
      logic                 bpack_wr;
      logic [NUM_LANES-1:0] ctrl_wr;
      logic                 pop;
   } strobe_t;

endpackage

// File: rtl/interp_decode.sv
module interp_decode
   import interp_pkg::*;
(
   input  logic       rd_en,
   input  logic [3:0] rd_addr,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   output strobe_t    strb
);

   reg_addr_e wa;
   reg_addr_e ra;

   assign wa = reg_addr_e'(wr_addr);
   assign ra = reg_addr_e'(rd_addr);

   always_comb begin
      strb = '0;
      if (wr_en) begin
         strb.acc_wr[0]  = (wa == RA_ACC0);
         strb.acc_wr[1]  = (wa == RA_ACC1);
         strb.add_wr[0]  = (wa == RA_ADD0);
         strb.add_wr[1]  = (wa == RA_ADD1);
         strb.base_wr[0] = (wa == RA_BASE0);
         strb.base_wr[1] = (wa == RA_BASE1);
         strb.base_wr[2] = (wa == RA_BASE2);
         strb.bpack_wr   = (wa == RA_BPACK);
         strb.ctrl_wr[0] = (wa == RA_CTRL0);
         strb.ctrl_wr[1] = (wa == RA_CTRL1);
      end
      if (rd_en)
         strb.pop = (ra == RA_POP0) || (ra == RA_POP1) || (ra == RA_POPF);
   end

endmodule

// File: rtl/interp_lane.sv
module interp_lane #(
   parameter int DATA_W = 32,
   localparam int SH_W   = $clog2(DATA_W),
   localparam int CTRL_W = 3*SH_W + 1
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] base,
   input  logic [CTRL_W-1:0] ctrl,
   output logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] res
);

   logic [SH_W-1:0]     rot_amt;
   logic [SH_W-1:0]     lo_bit;
   logic [SH_W-1:0]     hi_bit;
   logic                sgn;
   logic [2*DATA_W-1:0] doubled;
   logic [DATA_W-1:0]   rotated;
   logic [DATA_W-1:0]   masked;
   logic                top_bit;

   assign rot_amt = ctrl[SH_W-1:0];
   assign lo_bit  = ctrl[2*SH_W-1:SH_W];
   assign hi_bit  = ctrl[3*SH_W-1:2*SH_W];
   assign sgn     = ctrl[3*SH_W];

   assign doubled = {acc, acc} >> rot_amt;
   assign rotated = doubled[DATA_W-1:0];

   always_comb begin
      masked = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if ((i >= int'(lo_bit)) && (i <= int'(hi_bit)))
            masked[i] = rotated[i];
      end
      top_bit = masked[hi_bit];
      raw = masked;
      if (sgn) begin
         for (int i = 0; i < DATA_W; i++) begin
            if (i > int'(hi_bit))
               raw[i] = top_bit;
         end
      end
   end

   assign res = base + raw;

endmodule

// File: rtl/shift_mask_interp.sv
module shift_mask_interp
   import interp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [3:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int SH_W   = $clog2(DATA_W);
   localparam int CTRL_W = 3*SH_W + 1;
   localparam int HALF_W = DATA_W / 2;

   if ((1 << SH_W) != DATA_W || DATA_W < 16) begin : g_bad_width
      $error("shift_mask_interp: DATA_W must be a power of two of at least 16");
   end

   strobe_t           strb;
   logic [DATA_W-1:0] acc_q    [NUM_LANES];
   logic [DATA_W-1:0] base_q   [NUM_BASES];
   logic [CTRL_W-1:0] ctrl_q   [NUM_LANES];
   logic [DATA_W-1:0] lane_raw [NUM_LANES];
   logic [DATA_W-1:0] lane_res [NUM_LANES];
   logic [DATA_W-1:0] full_res;

   interp_decode u_decode (
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .strb    (strb)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      interp_lane #(.DATA_W(DATA_W)) u_lane (
         .acc  (acc_q[l]),
         .base (base_q[l]),
         .ctrl (ctrl_q[l]),
         .raw  (lane_raw[l]),
         .res  (lane_res[l])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q[l]  <= '0;
            ctrl_q[l] <= '0;
         end else begin
            if (strb.acc_wr[l])
               acc_q[l] <= wr_data;
            else if (strb.add_wr[l])
               acc_q[l] <= acc_q[l] + wr_data;
            else if (strb.pop)
               acc_q[l] <= lane_res[l];
            if (strb.ctrl_wr[l])
               ctrl_q[l] <= wr_data[CTRL_W-1:0];
         end
      end
   end

   function automatic logic [DATA_W-1:0] widen_half(input logic [HALF_W-1:0] h,
                                                    input logic sx);
      return sx ? {{HALF_W{h[HALF_W-1]}}, h} : {{HALF_W{1'b0}}, h};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BASES; b++) base_q[b] <= '0;
      end else begin
         for (int b = 0; b < NUM_BASES; b++)
            if (strb.base_wr[b]) base_q[b] <= wr_data;
         if (strb.bpack_wr) begin
            base_q[0] <= widen_half(wr_data[HALF_W-1:0], ctrl_q[0][CTRL_W-1]);
            base_q[1] <= widen_half(wr_data[DATA_W-1:HALF_W], ctrl_q[1][CTRL_W-1]);
         end
      end
   end

   assign full_res = base_q[2] + lane_raw[0] + lane_raw[1];

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         unique case (reg_addr_e'(rd_addr))
            RA_ACC0:           rd_data = acc_q[0];
            RA_ACC1:           rd_data = acc_q[1];
            RA_BASE0:          rd_data = base_q[0];
            RA_BASE1:          rd_data = base_q[1];
            RA_BASE2:          rd_data = base_q[2];
            RA_ADD0:           rd_data = lane_raw[0];
            RA_ADD1:           rd_data = lane_raw[1];
            RA_BPACK:          rd_data = '0;
            RA_CTRL0:          rd_data = DATA_W'(ctrl_q[0]);
            RA_CTRL1:          rd_data = DATA_W'(ctrl_q[1]);
            RA_PEEK0, RA_POP0: rd_data = lane_res[0];
            RA_PEEK1, RA_POP1: rd_data = lane_res[1];
            RA_PEEKF, RA_POPF: rd_data = full_res;
            default:           rd_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/interp_checker.sv
module interp_checker
   import interp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [3:0]        rd_addr,
   input logic              wr_en,
   input logic [3:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] acc0,
   input logic [DATA_W-1:0] acc1,
   input logic [DATA_W-1:0] res0,
   input logic [DATA_W-1:0] res1
);

   logic is_peek;
   logic is_pop;

   assign is_peek = rd_en && (rd_addr >= 4'd10) && (rd_addr <= 4'd12);
   assign is_pop  = rd_en && (rd_addr >= 4'd13);

   AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'd1) |=> (acc1 == $past(wr_data))); // R2

   AST_ADD_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'd5) |=> (acc0 == $past(acc0) + $past(wr_data))); // R7

   AST_PEEK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (is_peek && !wr_en) |=> ($stable(acc0) && $stable(acc1))); // R10

   AST_POP_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pop && !wr_en) |=> (acc0 == $past(res0) && acc1 == $past(res1))); // R11

   AST_WRITE_BEATS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pop && wr_en && wr_addr == 4'd0) |=> (acc0 == $past(wr_data) && acc1 == $past(res1))); // R12

endmodule

bind shift_mask_interp interp_checker #(.DATA_W(DATA_W)) u_interp_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .acc0    (acc_q[0]),
   .acc1    (acc_q[1]),
   .res0    (lane_res[0]),
   .res1    (lane_res[1])
);

// File: tb/tb_shift_mask_interp.sv
`timescale 1ns/1ps
module tb_shift_mask_interp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] m_acc [2];
   logic [31:0] m_base [3];
   logic [15:0] m_ctrl [2];

   always #4 clk = ~clk;

   shift_mask_interp dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [31:0] f_raw(input logic [31:0] a, input logic [15:0] c);
      logic [31:0] r, v;
      int sh, lo, hi;
      sh = int'(c[4:0]); lo = int'(c[9:5]); hi = int'(c[14:10]);
      r = (sh == 0) ? a : ((a >> sh) | (a << (32 - sh)));
      v = '0;
      for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) v[i] = r[i];
      if (c[15]) for (int i = 0; i < 32; i++) if (i > hi) v[i] = v[hi];
      return v;
   endfunction

   function automatic logic [31:0] f_read(input logic [3:0] a);
      logic [31:0] r0, r1;
      r0 = f_raw(m_acc[0], m_ctrl[0]);
      r1 = f_raw(m_acc[1], m_ctrl[1]);
      case (a)
         4'd0: return m_acc[0];
         4'd1: return m_acc[1];
         4'd2: return m_base[0];
         4'd3: return m_base[1];
         4'd4: return m_base[2];
         4'd5: return r0;
         4'd6: return r1;
         4'd8: return {16'd0, m_ctrl[0]};
         4'd9: return {16'd0, m_ctrl[1]};
         4'd10, 4'd13: return m_base[0] + r0;
         4'd11, 4'd14: return m_base[1] + r1;
         4'd12, 4'd15: return m_base[2] + r0 + r1;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string f_tag(input logic en, input logic [3:0] a);
      if (!en) return "R13";
      case (a)
         4'd5, 4'd6: return "R8";
         4'd7: return "R13";
         4'd10, 4'd11: return "R5";
         4'd12: return "R6";
         4'd13, 4'd14, 4'd15: return "R11";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One register-port cycle: drive after the falling edge, compare read data
   // in the same cycle, commit the model after the rising edge.
   task automatic cyc(input logic re, input logic [3:0] ra, input logic we,
                      input logic [3:0] wa, input logic [31:0] wd, input string tag);
      logic [31:0] n_acc [2];
      logic [31:0] n_base [3];
      logic [15:0] n_ctrl [2];
      logic [31:0] r0, r1;
      @(negedge clk);
      rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
      #1;
      check((tag == "") ? f_tag(re, ra) : tag, rd_data, re ? f_read(ra) : 32'd0);
      r0 = f_raw(m_acc[0], m_ctrl[0]);
      r1 = f_raw(m_acc[1], m_ctrl[1]);
      n_acc = m_acc; n_base = m_base; n_ctrl = m_ctrl;
      if (re && ra >= 4'd13) begin
         n_acc[0] = m_base[0] + r0;
         n_acc[1] = m_base[1] + r1;
      end
      if (we) begin
         case (wa)
            4'd0: n_acc[0] = wd;
            4'd1: n_acc[1] = wd;
            4'd2: n_base[0] = wd;
            4'd3: n_base[1] = wd;
            4'd4: n_base[2] = wd;
            4'd5: n_acc[0] = m_acc[0] + wd;
            4'd6: n_acc[1] = m_acc[1] + wd;
            4'd7: begin
               n_base[0] = m_ctrl[0][15] ? {{16{wd[15]}}, wd[15:0]} : {16'd0, wd[15:0]};
               n_base[1] = m_ctrl[1][15] ? {{16{wd[31]}}, wd[31:16]} : {16'd0, wd[31:16]};
            end
            4'd8: n_ctrl[0] = wd[15:0];
            4'd9: n_ctrl[1] = wd[15:0];
            default: ;
         endcase
      end
      @(posedge clk);
      m_acc = n_acc; m_base = n_base; m_ctrl = n_ctrl;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      cyc(1'b0, 4'd0, 1'b1, a, d, "");
   endtask

   task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; wr_en = 1'b0;
      #1;
      check(tag, rd_data, exp);
      @(posedge clk);
   endtask

   function automatic logic [15:0] mk_ctrl(input int sh, input int lo, input int hi, input bit s);
      return {s, 5'(hi), 5'(lo), 5'(sh)};
   endfunction

   initial begin
      logic [31:0] snap0, snap1;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ctrl[i] = '0; end
      for (int i = 0; i < 3; i++) m_base[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every address reads zero out of reset
      for (int a = 0; a < 16; a++) expect_rd(4'(a), 32'd0, "R1");

      // R3: rotate by 4, full mask
      wr(4'd0, 32'h1234_5678);
      wr(4'd8, {16'd0, mk_ctrl(4, 0, 31, 1'b0)});
      expect_rd(4'd5, 32'h8123_4567, "R3");
      // R3: narrow field, no rotate
      wr(4'd8, {16'd0, mk_ctrl(0, 4, 11, 1'b0)});
      expect_rd(4'd5, 32'h0000_0670, "R3");
      // R3: empty range
      wr(4'd8, {16'd0, mk_ctrl(0, 12, 11, 1'b0)});
      expect_rd(4'd5, 32'h0000_0000, "R3");
      // R4: sign extension from the high mask bit
      wr(4'd0, 32'h0000_0F00);
      wr(4'd8, {16'd0, mk_ctrl(0, 8, 11, 1'b1)});
      expect_rd(4'd5, 32'hFFFF_FF00, "R4");
      // R2: control keeps only 16 bits
      wr(4'd9, 32'hABCD_1234);
      expect_rd(4'd9, 32'h0000_1234, "R2");
      // R5: base plus raw
      wr(4'd2, 32'd256);
      expect_rd(4'd10, 32'h0000_0000, "R5");
      // R6: full sum
      wr(4'd1, 32'h0000_0010);
      wr(4'd9, {16'd0, mk_ctrl(0, 0, 7, 1'b0)});
      wr(4'd4, 32'd7);
      expect_rd(4'd12, 32'd7 + 32'hFFFF_FF00 + 32'h10, "R6");
      // R7: add port accumulates
      wr(4'd6, 32'd5);
      expect_rd(4'd1, 32'h0000_0015, "R7");
      wr(4'd6, 32'hFFFF_FFFF);
      expect_rd(4'd1, 32'h0000_0014, "R7");
      // R9: packed bases, lane 0 signed, lane 1 unsigned
      wr(4'd7, 32'h8001_8002);
      expect_rd(4'd2, 32'hFFFF_8002, "R9");
      expect_rd(4'd3, 32'h0000_8001, "R9");
      // R10: peeks leave the accumulators alone
      snap0 = m_acc[0]; snap1 = m_acc[1];
      cyc(1'b1, 4'd10, 1'b0, 4'd0, 32'd0, "R10");
      cyc(1'b1, 4'd12, 1'b0, 4'd0, 32'd0, "R10");
      expect_rd(4'd0, snap0, "R10");
      expect_rd(4'd1, snap1, "R10");
      // R11: pop writes both lane results back
      snap0 = f_read(4'd10); snap1 = f_read(4'd11);
      cyc(1'b1, 4'd15, 1'b0, 4'd0, 32'd0, "R11");
      expect_rd(4'd0, snap0, "R11");
      expect_rd(4'd1, snap1, "R11");
      // R12: a write beats a coinciding pop on its own accumulator
      snap0 = f_read(4'd10);
      cyc(1'b1, 4'd13, 1'b1, 4'd1, 32'hCAFE_0001, "R11");
      expect_rd(4'd1, 32'hCAFE_0001, "R12");
      expect_rd(4'd0, snap0, "R12");
      // R13: idle port and write-only address read zero
      cyc(1'b0, 4'd0, 1'b0, 4'd0, 32'd0, "R13");
      expect_rd(4'd7, 32'd0, "R13");

      // Random traffic checked against the model
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] d;
         logic [3:0] wa;
         wa = 4'($urandom_range(0, 15));
         d = $urandom;
         if (wa == 4'd8 || wa == 4'd9) d[15] = ($urandom_range(0, 3) == 0);
         cyc($urandom_range(0, 4) != 0, 4'($urandom_range(0, 15)),
             $urandom_range(0, 2) == 0, wa, d, "");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule